// File: doc/BRIEF.md
# LED Port Status Field Formatter

This block builds, for each of eight network ports, the short bit field that a downstream LED shift-chain serializer clocks out for that port. Each field mixes software-supplied status bits with indicators of transmit and receive activity. A 4-bit format code selects the mix. The same code applies to all ports. An 8-bit enable mask chooses which ports contribute a field at all.

Activity strobes are often only a cycle long, so each one is stretched. The indicator stays lit for a programmable number of serializer latch events, which is the blink period. Every port has its own transmit and receive stretch counters. When a strobe arrives, the counter reloads to the blink rate. On each latch tick from the serializer, the counter steps down. The serializer takes the field and its width for every port.

Top module: `led_status_fmt`

## Requirements
- R1: Status-only codes. Code 0x0 gives field = status[0] (width 1). 0x1 gives status[1:0] (width 2). 0x2 gives status[3:0] (width 4). 0x3 gives status[5:0] (width 6). Field bit 0 is the bit sent first, and status is placed LSB first.
- R2: Merged-activity codes 0x4, 0x5 and 0x6 place (tx indicator OR rx indicator) in field bit 0. They then place status[0], status[1:0] or status[3:0] from bit 1 upward. The widths are 2, 3 and 5.
- R3: Split-activity codes 0x8, 0x9 and 0xA place the tx indicator in bit 0 and the rx indicator in bit 1. They then place status[0], status[1:0] or status[3:0] from bit 2 upward. The widths are 3, 4 and 6. Each port's indicators depend only on that port's own strobes.
- R4: Codes 0x7 and 0xB through 0xF are reserved. For these codes, every port reports width 0 and field 0.
- R5: Enable bit i controls port i. A port whose enable bit is 0 reports width 0 and field 0, whatever the code, status or activity.
- R6: An indicator goes high in the cycle after a strobe is sampled. It stays high until `blink_rate` latch ticks have been sampled with no further strobe. It then goes low.
- R7: A blink rate of 0 behaves as a blink rate of 1.
- R8: Suppose a strobe and a latch tick are sampled in the same cycle. The strobe wins: the counter reloads to the full blink rate, and that tick does not count down.
- R9: Reset (asynchronous assert, synchronous release) clears every stretch counter, so all indicators read low afterwards.
- R10: Field bits at and above the reported width are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_act | input | 8 | Per-port transmit activity strobe |
| rx_act | input | 8 | Per-port receive activity strobe |
| port_status | input | 48 | Software status, 6 bits per port, port 0 in bits 5:0 |
| port_en | input | 8 | Port enable mask, bit i for port i |
| fmt_code | input | 4 | Field format code |
| blink_rate | input | 8 | Stretch length in latch ticks |
| latch_tick | input | 1 | One-cycle pulse per serializer frame latch |
| field_out | output | 64 | Per-port field, 8 bits per port, port 0 in bits 7:0 |
| width_out | output | 32 | Per-port field width, 4 bits per port |

## Verification
A fresh activity strobe and a serializer latch tick can land in the same cycle. Both then compete for the same stretch counter. The bench provokes this during a running stretch with a blink rate of 2. It first spends one tick, then drives a strobe and a tick together. It then counts further ticks to judge whether the indicator was reloaded to the full period rather than decremented. A one-tick-early extinguish, or an indicator that outlives the second tick, is a failure.

// File: rtl/led_fmt_pkg.sv
package led_fmt_pkg;

  localparam int ST_W  = 6;
  localparam int FMT_W = 4;
  localparam int FLD_W = ST_W + 2;
  localparam int FLDWW = $clog2(FLD_W + 1);

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_MERGED = 2'd1,
    ACT_SPLIT  = 2'd2,
    ACT_BAD    = 2'd3
  } act_mode_e;

  typedef struct packed {
    logic      ok;
    act_mode_e mode;
    logic [2:0] nstat;
  } fmt_dec_t;

  // Upper two code bits pick the activity prefix, lower two the status count.
  function automatic fmt_dec_t decode_fmt(input logic [FMT_W-1:0] code);
    fmt_dec_t d;
    d.mode = act_mode_e'(code[3:2]);
    case (code[1:0])
      2'd0:    d.nstat = 3'd1;
      2'd1:    d.nstat = 3'd2;
      2'd2:    d.nstat = 3'd4;
      default: d.nstat = 3'd6;
    endcase
    d.ok = (d.mode != ACT_BAD) && !((d.mode != ACT_NONE) && (code[1:0] == 2'd3));
    return d;
  endfunction

endpackage

// File: rtl/led_act_stretch.sv
module led_act_stretch #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_s,
  input  logic              strobe,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  output logic              ind
);

  logic [RATE_W-1:0] cnt_q, cnt_d, rate_eff;
  logic              cnt_en;

  always_comb begin
    rate_eff = (rate == '0) ? RATE_W'(1) : rate;
    cnt_en   = strobe || (tick && (cnt_q != '0));
    if (strobe) cnt_d = rate_eff;
    else        cnt_d = cnt_q - RATE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ind = (cnt_q != '0);

  assert_seen_R6: assert property (@(posedge clk) disable iff (!rst_s)
    strobe |=> ind);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (!strobe && !tick) |=> $stable(cnt_q));
  assert_fall_R7: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(ind) |-> $past(tick && !strobe));
  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (strobe && tick) |=> (cnt_q == $past(rate_eff)));

endmodule

// File: rtl/led_field_pack.sv
module led_field_pack
  import led_fmt_pkg::*;
(
  input  fmt_dec_t         dec,
  input  logic             en,
  input  logic             tx_ind,
  input  logic             rx_ind,
  input  logic [ST_W-1:0]  status,
  output logic [FLD_W-1:0] field,
  output logic [FLDWW-1:0] width
);

  logic [1:0]       lead_n;
  logic [FLD_W-1:0] lead, smask, stat_sh;

  always_comb begin
    case (dec.mode)
      ACT_MERGED: begin lead_n = 2'd1; lead = FLD_W'(tx_ind | rx_ind); end
      ACT_SPLIT:  begin lead_n = 2'd2; lead = FLD_W'({rx_ind, tx_ind}); end
      default:    begin lead_n = 2'd0; lead = '0; end
    endcase
    smask   = (FLD_W'(1) << dec.nstat) - FLD_W'(1);
    stat_sh = (FLD_W'(status) & smask) << lead_n;
    if (dec.ok && en) begin
      field = lead | stat_sh;
      width = FLDWW'(lead_n) + FLDWW'(dec.nstat);
    end else begin
      field = '0;
      width = '0;
    end
  end

endmodule

// File: rtl/led_status_fmt.sv
module led_status_fmt
  import led_fmt_pkg::*;
#(
  parameter int NPORT  = 8,
  parameter int RATE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       tx_act,
  input  logic [NPORT-1:0]       rx_act,
  input  logic [NPORT*ST_W-1:0]  port_status,
  input  logic [NPORT-1:0]       port_en,
  input  logic [FMT_W-1:0]       fmt_code,
  input  logic [RATE_W-1:0]      blink_rate,
  input  logic                   latch_tick,
  output logic [NPORT*FLD_W-1:0] field_out,
  output logic [NPORT*FLDWW-1:0] width_out
);

  logic [1:0] rst_sync_q;
  logic       rst_s;
  fmt_dec_t   dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign dec = decode_fmt(fmt_code);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic tx_ind, rx_ind;
    logic [FLD_W-1:0] fld;
    logic [FLDWW-1:0] wid;

    led_act_stretch #(.RATE_W(RATE_W)) u_tx (
      .clk(clk), .rst_s(rst_s), .strobe(tx_act[p]), .tick(latch_tick),
      .rate(blink_rate), .ind(tx_ind));
    led_act_stretch #(.RATE_W(RATE_W)) u_rx (
      .clk(clk), .rst_s(rst_s), .strobe(rx_act[p]), .tick(latch_tick),
      .rate(blink_rate), .ind(rx_ind));
    led_field_pack u_pack (
      .dec(dec), .en(port_en[p]), .tx_ind(tx_ind), .rx_ind(rx_ind),
      .status(port_status[p*ST_W +: ST_W]), .field(fld), .width(wid));

    assign field_out[p*FLD_W +: FLD_W] = fld;
    assign width_out[p*FLDWW +: FLDWW] = wid;

    assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_s)
      !port_en[p] |-> (fld == '0 && wid == '0));
    assert_reserved_R4: assert property (@(posedge clk) disable iff (!rst_s)
      (fmt_code == 4'h7 || fmt_code > 4'hA) |-> (wid == '0));
    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_s)
      ((fld >> wid) == '0));
    assert_width_max_R10: assert property (@(posedge clk) disable iff (!rst_s)
      (wid <= FLDWW'(FLD_W - 2)));
  end

endmodule

// File: tb/led_status_fmt_bench.sv
module led_status_fmt_bench;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NP-1:0]   tx_act, rx_act, port_en;
  logic [5:0]      st;
  logic [3:0]      fmt_code;
  logic [7:0]      blink_rate;
  logic            latch_tick;
  logic [NP*8-1:0] field_out;
  logic [NP*4-1:0] width_out;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  led_status_fmt u_led_status_fmt (
    .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
    .port_status({NP{st}}), .port_en(port_en), .fmt_code(fmt_code),
    .blink_rate(blink_rate), .latch_tick(latch_tick),
    .field_out(field_out), .width_out(width_out));

  // {fmt, status, tx, rx, field, width}
  localparam logic [23:0] VEC [17] = '{
    {4'h0, 6'h2D, 1'b0, 1'b0, 8'h01, 4'd1},   // R1
    {4'h1, 6'h2D, 1'b0, 1'b0, 8'h01, 4'd2},   // R1
    {4'h2, 6'h2D, 1'b0, 1'b0, 8'h0D, 4'd4},   // R1
    {4'h3, 6'h2D, 1'b0, 1'b0, 8'h2D, 4'd6},   // R1
    {4'h3, 6'h12, 1'b1, 1'b1, 8'h12, 4'd6},   // R1
    {4'h4, 6'h2D, 1'b1, 1'b0, 8'h03, 4'd2},   // R2
    {4'h5, 6'h2D, 1'b0, 1'b1, 8'h03, 4'd3},   // R2
    {4'h6, 6'h2D, 1'b0, 1'b0, 8'h1A, 4'd5},   // R2
    {4'h8, 6'h2D, 1'b1, 1'b0, 8'h05, 4'd3},   // R3
    {4'h9, 6'h2D, 1'b0, 1'b1, 8'h06, 4'd4},   // R3
    {4'hA, 6'h2D, 1'b1, 1'b1, 8'h37, 4'd6},   // R3
    {4'hA, 6'h12, 1'b0, 1'b0, 8'h08, 4'd6},   // R3
    {4'h7, 6'h2D, 1'b1, 1'b1, 8'h00, 4'd0},   // R4
    {4'hB, 6'h2D, 1'b1, 1'b0, 8'h00, 4'd0},   // R4
    {4'hF, 6'h3F, 1'b0, 1'b1, 8'h00, 4'd0},   // R4
    {4'hC, 6'h2D, 1'b0, 1'b0, 8'h00, 4'd0},   // R4
    {4'h3, 6'h00, 1'b1, 1'b1, 8'h00, 4'd6}    // R10
  };

  task automatic chk(input string req, input logic [NP*8-1:0] gf, input logic [NP*8-1:0] ef,
                     input logic [NP*4-1:0] gw, input logic [NP*4-1:0] ew);
    n_chk++;
    if (gf !== ef || gw !== ew) begin
      n_fail++;
      $display("FAIL %s field=%h width=%h expected field=%h width=%h", req, gf, gw, ef, ew);
    end
  endtask

  task automatic chk_bit(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s indicator=%b expected %b", req, got, exp);
    end
  endtask

  // one latch tick, sampled after it is taken
  task automatic tick_once();
    @(negedge clk); latch_tick = 1'b1;
    @(negedge clk); latch_tick = 1'b0;
    #1;
  endtask

  task automatic pulse(input logic [NP-1:0] t, input logic [NP-1:0] r);
    @(negedge clk); tx_act = t; rx_act = r;
    @(negedge clk); tx_act = '0; rx_act = '0;
    #1;
  endtask

  task automatic clear_all();
    blink_rate = 8'd1;
    tick_once();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired, all requirements unfinished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_act = '0; rx_act = '0; port_en = '1; st = '0;
    fmt_code = 4'hA; blink_rate = 8'd1; latch_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R9: after reset all indicators low, split format with zero status
    chk("R9 reset state", field_out, '0, width_out, {NP{4'd6}});

    // table walk: R1 R2 R3 R4 R10
    foreach (VEC[i]) begin
      clear_all();
      fmt_code = VEC[i][23:20]; st = VEC[i][19:14];
      pulse({NP{VEC[i][13]}}, {NP{VEC[i][12]}});
      chk($sformatf("R1-4 table entry %0d fmt %h", i, VEC[i][23:20]),
          field_out, {NP{VEC[i][11:4]}}, width_out, {NP{VEC[i][3:0]}});
    end

    // R5: ports 4..7 disabled
    clear_all();
    fmt_code = 4'h3; st = 6'h2D; port_en = 8'h0F;
    #1 chk("R5 upper ports disabled", field_out, {{4{8'h00}}, {4{8'h2D}}},
           width_out, {{4{4'd0}}, {4{4'd6}}});
    fmt_code = 4'hA; port_en = 8'h80;
    pulse('1, '1);
    chk("R5 only port 7 enabled", field_out, {8'h37, {7{8'h00}}},
        width_out, {4'd6, {7{4'd0}}});
    port_en = '1;

    // R3: per-port independence, rx on port 5 only
    clear_all();
    fmt_code = 4'h8; st = 6'h00;
    pulse(8'h00, 8'h20);
    chk("R3 rx on port 5 only", field_out, {{2{8'h00}}, 8'h02, {5{8'h00}}},
        width_out, {NP{4'd3}});

    // R6: rate 3 stretch, ticks counted
    clear_all();
    blink_rate = 8'd3; fmt_code = 4'h8;
    pulse(8'h01, 8'h00);
    chk_bit("R6 lit before any tick", field_out[0], 1'b1);
    tick_once(); chk_bit("R6 lit after tick 1", field_out[0], 1'b1);
    repeat (3) @(negedge clk);
    #1 chk_bit("R6 held without ticks", field_out[0], 1'b1);
    tick_once(); chk_bit("R6 lit after tick 2", field_out[0], 1'b1);
    tick_once(); chk_bit("R6 dark after tick 3", field_out[0], 1'b0);

    // R7: rate 0 acts as 1
    blink_rate = 8'd0;
    pulse(8'h00, 8'h01);
    chk_bit("R7 rate0 lit", field_out[1], 1'b1);
    tick_once(); chk_bit("R7 rate0 dark after one tick", field_out[1], 1'b0);

    // R8: strobe and tick in same cycle reload
    blink_rate = 8'd2;
    pulse(8'h01, 8'h00);
    tick_once(); chk_bit("R8 lit after first tick", field_out[0], 1'b1);
    @(negedge clk); tx_act = 8'h01; latch_tick = 1'b1;
    @(negedge clk); tx_act = '0; latch_tick = 1'b0;
    tick_once(); chk_bit("R8 reloaded, lit after next tick", field_out[0], 1'b1);
    tick_once(); chk_bit("R8 dark after second tick", field_out[0], 1'b0);

    // R9: reset in the middle of a stretch
    blink_rate = 8'd200;
    pulse('1, '1);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk("R9 reset clears stretch", field_out, '0, width_out, {NP{4'd3}});

    summary();
    $finish;
  end
endmodule